// File: doc/BRIEF.md
# Single-Cycle 32-Bit Load/Store Processor Core

This block is a 32-bit processor core that completes every instruction in one clock period. On each rising edge it commits the program counter, at most one register-file write and at most one data-memory write. All of these are computed combinationally from the instruction word that the current program counter selects. The core supports eight operations: four arithmetic/logic register operations, a signed set-less-than, a word load, a word store and a branch on equality.

Instruction memory and data memory are internal word arrays. Both read combinationally and both write on the clock edge. A loader port fills either array. It is normally used while reset is held, so a program and its operands are in place before execution starts. Two observation ports expose one register-file entry and one data-memory word, so results can be examined at the block's boundary.

Decoding happens in two levels. A main decoder turns the 6-bit opcode into control strobes and a 2-bit ALU class. An ALU decoder then refines that class into a 3-bit ALU function, using the funct field when the instruction is a register operation.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 on that edge.
- R2: Opcode 000000 is a register operation that writes `rd` (bits 15:11) with the result of `rs` (bits 25:21) and `rt` (bits 20:16). The operation is chosen by funct (bits 5:0): 100000 adds, 100010 subtracts (rs minus rt), 100100 takes the AND and 100101 takes the OR.
- R3: With opcode 000000 and funct 101010, `rd` receives 1 when `rs` is less than `rt` as signed two's-complement numbers, and 0 otherwise.
- R4: Opcode 100011 loads the data word at byte address `rs` + sign-extended imm (bits 15:0) into `rt`. The word index is address bits [MAW+1:2].
- R5: Opcode 101011 stores `rt` into the data word at byte address `rs` + sign-extended imm.
- R6: Opcode 000100 compares `rs` with `rt`. If they are equal, the next PC is PC + 4 + (sign-extended imm shifted left by 2). Otherwise the next PC is PC + 4.
- R7: Every instruction other than a taken branch advances the PC by 4. Any opcode outside the four listed writes neither the register file nor data memory.
- R8: Register 0 always reads as zero, and writes addressed to it are discarded.
- R9: The main decoder emits ALU class 00 (add) for load and store, 01 (subtract) for the branch, and 10 (use funct) for register operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset; clears the PC and blocks core writes |
| ld_we | input | 1 | Loader write strobe |
| ld_to_dmem | input | 1 | Loader target: 1 writes data memory, 0 writes instruction memory |
| ld_addr | input | MAW | Loader word index |
| ld_data | input | 32 | Loader write data |
| dbg_reg | input | 5 | Register number to observe |
| dbg_reg_data | output | 32 | Value of the observed register (combinational) |
| dbg_daddr | input | MAW | Data-memory word index to observe |
| dbg_ddata | output | 32 | Value of the observed data word (combinational) |
| pc_o | output | 32 | Current program counter |

## Verification
Some behaviours are checked by assertions on every cycle:
- the PC after reset;
- the PC step for non-branch instructions;
- both outcomes of the branch target, computed from the instruction bits;
- the zero reading of register 0;
- the absence of writes for unknown opcodes;
- the ALU class chosen for each opcode.

Other behaviours can only be shown by the bench's program runs, swept over operand pairs that include sign boundaries and equal values:
- the arithmetic values actually written back;
- the signed ordering of set-less-than;
- load and store addressing with a negative offset;
- a skipped instruction after a taken forward branch.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10,
        CLS_NONE  = 2'b11
    } alu_cls_e;

    typedef enum logic [2:0] {
        ALU_AND  = 3'b000,
        ALU_OR   = 3'b001,
        ALU_ADD  = 3'b010,
        ALU_RSVD = 3'b011,
        ALU_ANDN = 3'b100,
        ALU_ORN  = 3'b101,
        ALU_SUB  = 3'b110,
        ALU_SLT  = 3'b111
    } alu_fn_e;

    typedef struct packed {
        logic     reg_we;
        logic     dst_is_rd;
        logic     src_is_imm;
        logic     mem_we;
        logic     wb_from_mem;
        logic     is_branch;
        alu_cls_e alu_cls;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctl
);

    always_comb begin
        ctl         = '0;
        ctl.alu_cls = CLS_ADD;
        case (opcode)
            OP_RTYPE: begin
                ctl.reg_we    = 1'b1;
                ctl.dst_is_rd = 1'b1;
                ctl.alu_cls   = CLS_FUNCT;
            end
            OP_LW: begin
                ctl.reg_we      = 1'b1;
                ctl.src_is_imm  = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.alu_cls     = CLS_ADD;
            end
            OP_SW: begin
                ctl.mem_we     = 1'b1;
                ctl.src_is_imm = 1'b1;
                ctl.alu_cls    = CLS_ADD;
            end
            OP_BEQ: begin
                ctl.is_branch = 1'b1;
                ctl.alu_cls   = CLS_SUB;
            end
            default: begin
                ctl.alu_cls = CLS_ADD;
            end
        endcase
    end

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_pkg::*;
(
    input  alu_cls_e   cls,
    input  logic [5:0] funct,
    output alu_fn_e    fn
);

    always_comb begin
        case (cls)
            CLS_ADD: fn = ALU_ADD;
            CLS_SUB: fn = ALU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  fn = ALU_ADD;
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn = ALU_RSVD;
                endcase
            end
            default: fn = ALU_RSVD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y
);

    always_comb begin
        case (fn)
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_ADD:  y = a + b;
            ALU_ANDN: y = a & ~b;
            ALU_ORN:  y = a | ~b;
            ALU_SUB:  y = a - b;
            ALU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd3
);

    logic [W-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs_q[ra3];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int  MEM_WORDS = 64,
    localparam int MAW       = $clog2(MEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_we,
    input  logic            ld_to_dmem,
    input  logic [MAW-1:0]  ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [4:0]      dbg_reg,
    output logic [XLEN-1:0] dbg_reg_data,
    input  logic [MAW-1:0]  dbg_daddr,
    output logic [XLEN-1:0] dbg_ddata,
    output logic [XLEN-1:0] pc_o
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [XLEN-1:0] imem_q [MEM_WORDS];
    logic [XLEN-1:0] dmem_q [MEM_WORDS];

    logic [XLEN-1:0] instr;
    logic [5:0]      opcode;
    logic [4:0]      rs, rt, rd;
    logic [5:0]      funct;
    logic [15:0]     imm;
    logic            unused_shamt;

    ctrl_t           ctl;
    logic [1:0]      alu_cls_w;
    alu_fn_e         fn;

    logic [XLEN-1:0] rs_val, rt_val;
    logic [XLEN-1:0] sext, srcb, alu_y, mem_rdata, wb_data;
    logic [4:0]      wa;
    logic            rf_we, dm_we;
    logic [XLEN-1:0] pc_plus4, br_tgt;
    logic            take;
    logic [MAW-1:0]  d_idx;

    // fetch and field split
    assign instr        = imem_q[st_q.pc[MAW+1:2]];
    assign opcode       = instr[31:26];
    assign rs           = instr[25:21];
    assign rt           = instr[20:16];
    assign rd           = instr[15:11];
    assign funct        = instr[5:0];
    assign imm          = instr[15:0];
    assign unused_shamt = ^instr[10:6];

    sc_main_dec u_main_dec (
        .opcode (opcode),
        .ctl    (ctl)
    );

    assign alu_cls_w = ctl.alu_cls;

    sc_alu_dec u_alu_dec (
        .cls   (ctl.alu_cls),
        .funct (funct),
        .fn    (fn)
    );

    sc_regfile #(
        .NREG (32),
        .W    (XLEN)
    ) u_rf (
        .clk (clk),
        .we  (rf_we),
        .wa  (wa),
        .wd  (wb_data),
        .ra1 (rs),
        .rd1 (rs_val),
        .ra2 (rt),
        .rd2 (rt_val),
        .ra3 (dbg_reg),
        .rd3 (dbg_reg_data)
    );

    assign sext = {{(XLEN-16){imm[15]}}, imm};
    assign srcb = ctl.src_is_imm ? sext : rt_val;

    sc_alu #(
        .W (XLEN)
    ) u_alu (
        .a  (rs_val),
        .b  (srcb),
        .fn (fn),
        .y  (alu_y)
    );

    // memory stage and write-back
    assign d_idx     = alu_y[MAW+1:2];
    assign mem_rdata = dmem_q[d_idx];
    assign wb_data   = ctl.wb_from_mem ? mem_rdata : alu_y;
    assign wa        = ctl.dst_is_rd ? rd : rt;
    assign rf_we     = ctl.reg_we & ~rst;
    assign dm_we     = ctl.mem_we & ~rst;

    // next PC
    assign pc_plus4 = st_q.pc + XLEN'(4);
    assign br_tgt   = pc_plus4 + {sext[XLEN-3:0], 2'b00};
    assign take     = ctl.is_branch & (alu_y == '0);

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (take) begin
            st_d.pc = br_tgt;
        end else begin
            st_d.pc = pc_plus4;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (ld_we && !ld_to_dmem) begin
            imem_q[ld_addr] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_we && ld_to_dmem) begin
            dmem_q[ld_addr] <= ld_data;
        end else if (dm_we) begin
            dmem_q[d_idx] <= rt_val;
        end
    end

    assign dbg_ddata = dmem_q[dbg_daddr];
    assign pc_o      = st_q.pc;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        reg_we,
    input logic        mem_we,
    input logic [1:0]  alu_cls,
    input logic [4:0]  dbg_reg,
    input logic [31:0] dbg_reg_data,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val
);

    logic [5:0] op;
    logic       known;

    assign op    = instr[31:26];
    assign known = (op == 6'b000000) || (op == 6'b100011) ||
                   (op == 6'b101011) || (op == 6'b000100);

    assert_pc_reset_R1: assert property (@(posedge clk)
        rst |=> (pc == 32'h0));

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
        (op != 6'b000100) |=> (pc == $past(pc) + 32'd4));

    assert_beq_taken_R6: assert property (@(posedge clk) disable iff (rst)
        ((op == 6'b000100) && (rs_val == rt_val)) |=>
        (pc == $past(pc) + 32'd4 + $past({{14{instr[15]}}, instr[15:0], 2'b00})));

    assert_beq_fall_R6: assert property (@(posedge clk) disable iff (rst)
        ((op == 6'b000100) && (rs_val != rt_val)) |=> (pc == $past(pc) + 32'd4));

    assert_r0_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (dbg_reg == 5'd0) |-> (dbg_reg_data == 32'h0));

    assert_unknown_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !known |-> (!reg_we && !mem_we));

    assert_cls_mem_R9: assert property (@(posedge clk) disable iff (rst)
        ((op == 6'b100011) || (op == 6'b101011)) |-> (alu_cls == 2'b00));

    assert_cls_beq_R9: assert property (@(posedge clk) disable iff (rst)
        (op == 6'b000100) |-> (alu_cls == 2'b01));

    assert_cls_rtype_R9: assert property (@(posedge clk) disable iff (rst)
        (op == 6'b000000) |-> (alu_cls == 2'b10));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pc           (pc_o),
    .instr        (instr),
    .reg_we       (rf_we),
    .mem_we       (dm_we),
    .alu_cls      (alu_cls_w),
    .dbg_reg      (dbg_reg),
    .dbg_reg_data (dbg_reg_data),
    .rs_val       (rs_val),
    .rt_val       (rt_val)
);

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;

    localparam int MW  = 64;
    localparam int MAW = $clog2(MW);
    localparam logic [31:0] MARK = 32'hDEAD_BEEF;
    localparam logic [31:0] FAR  = 32'hC0FF_EE00;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ld_we = 1'b0;
    logic            ld_to_dmem = 1'b0;
    logic [MAW-1:0]  ld_addr = '0;
    logic [31:0]     ld_data = '0;
    logic [4:0]      dbg_reg = '0;
    logic [31:0]     dbg_reg_data;
    logic [MAW-1:0]  dbg_daddr = '0;
    logic [31:0]     dbg_ddata;
    logic [31:0]     pc_o;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    sc_core #(.MEM_WORDS(MW)) u0 (
        .clk          (clk),
        .rst          (rst),
        .ld_we        (ld_we),
        .ld_to_dmem   (ld_to_dmem),
        .ld_addr      (ld_addr),
        .ld_data      (ld_data),
        .dbg_reg      (dbg_reg),
        .dbg_reg_data (dbg_reg_data),
        .dbg_daddr    (dbg_daddr),
        .dbg_ddata    (dbg_ddata),
        .pc_o         (pc_o)
    );

    function automatic logic [31:0] enc_r(input int s, input int t, input int d, input logic [5:0] f);
        return {6'b000000, s[4:0], t[4:0], d[4:0], 5'b00000, f};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input logic [15:0] im);
        return {op, s[4:0], t[4:0], im};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input logic to_d, input int idx, input logic [31:0] val);
        @(negedge clk);
        ld_we      = 1'b1;
        ld_to_dmem = to_d;
        ld_addr    = idx[MAW-1:0];
        ld_data    = val;
        @(negedge clk);
        ld_we      = 1'b0;
    endtask

    task automatic peek_reg(input int r, output logic [31:0] v);
        dbg_reg = r[4:0];
        #0.5;
        v = dbg_reg_data;
    endtask

    task automatic peek_mem(input int a, output logic [31:0] v);
        dbg_daddr = a[MAW-1:0];
        #0.5;
        v = dbg_ddata;
    endtask

    logic [31:0] vals [8];

    initial begin
        vals[0] = 32'h0000_0000;
        vals[1] = 32'h0000_0001;
        vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF;
        vals[4] = 32'h8000_0000;
        vals[5] = 32'h0000_0005;
        vals[6] = 32'h1234_5678;
        vals[7] = 32'hFFFF_FFFE;

        // fill instruction memory with an unknown opcode, then the program
        for (int i = 0; i < MW; i++) load(1'b0, i, 32'hFFFF_FFFF);
        load(1'b0,  0, enc_i(6'b100011, 0, 1, 16'd0));     // lw r1,0(r0)
        load(1'b0,  1, enc_i(6'b100011, 0, 2, 16'd4));     // lw r2,4(r0)
        load(1'b0,  2, enc_r(1, 2, 3, 6'b100000));         // add
        load(1'b0,  3, enc_r(1, 2, 4, 6'b100010));         // sub
        load(1'b0,  4, enc_r(1, 2, 5, 6'b100100));         // and
        load(1'b0,  5, enc_r(1, 2, 6, 6'b100101));         // or
        load(1'b0,  6, enc_r(1, 2, 7, 6'b101010));         // slt
        load(1'b0,  7, enc_i(6'b101011, 0, 3, 16'd8));
        load(1'b0,  8, enc_i(6'b101011, 0, 4, 16'd12));
        load(1'b0,  9, enc_i(6'b101011, 0, 5, 16'd16));
        load(1'b0, 10, enc_i(6'b101011, 0, 6, 16'd20));
        load(1'b0, 11, enc_i(6'b101011, 0, 7, 16'd24));
        load(1'b0, 12, enc_r(1, 2, 0, 6'b100000));         // add r0 (discarded)
        load(1'b0, 13, enc_i(6'b101011, 0, 0, 16'd28));    // sw r0 -> word 7
        load(1'b0, 14, enc_i(6'b000100, 1, 2, 16'd1));     // beq r1,r2,+1
        load(1'b0, 15, enc_i(6'b101011, 0, 1, 16'd32));    // sw r1 -> word 8
        load(1'b0, 16, enc_i(6'b100011, 0, 9, 16'd40));    // lw r9,40(r0)
        load(1'b0, 17, enc_i(6'b100011, 9, 8, 16'hFFFC));  // lw r8,-4(r9)
        load(1'b0, 18, {6'b111111, 5'd0, 5'd3, 16'h0000}); // unknown, rt=r3
        load(1'b0, 19, enc_i(6'b000100, 0, 0, 16'hFFFF));  // beq r0,r0,-1 halt

        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [31:0] a, b, v, e_slt;
                a = vals[i];
                b = vals[j];
                rst = 1'b1;
                load(1'b1, 0, a);
                load(1'b1, 1, b);
                load(1'b1, 7, 32'h1111_1111);
                load(1'b1, 8, MARK);
                load(1'b1, 10, 32'd52);
                load(1'b1, 12, FAR);
                chk("R1 pc in reset", pc_o, 32'h0);
                rst = 1'b0;
                @(negedge clk);
                chk("R7 pc after first lw", pc_o, 32'd4);
                repeat (30) @(negedge clk);

                e_slt = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                peek_reg(3, v); chk("R2 R7 add kept past unknown op", v, a + b);
                peek_reg(4, v); chk("R2 sub", v, a - b);
                peek_reg(5, v); chk("R2 and", v, a & b);
                peek_reg(6, v); chk("R2 or", v, a | b);
                peek_reg(7, v); chk("R3 slt signed", v, e_slt);
                peek_reg(9, v); chk("R4 lw base", v, 32'd52);
                peek_reg(8, v); chk("R4 R9 lw negative offset", v, FAR);
                peek_reg(0, v); chk("R8 r0 reads zero", v, 32'h0);
                peek_mem(2, v); chk("R5 R9 sw add", v, a + b);
                peek_mem(3, v); chk("R5 sw sub", v, a - b);
                peek_mem(4, v); chk("R5 sw and", v, a & b);
                peek_mem(5, v); chk("R5 sw or", v, a | b);
                peek_mem(6, v); chk("R5 R3 sw slt", v, e_slt);
                peek_mem(7, v); chk("R8 stored r0", v, 32'h0);
                peek_mem(8, v); chk("R6 R9 beq skip", v, (a == b) ? MARK : a);
                peek_mem(0, v); chk("R7 unknown op no store", v, a);
                chk("R6 backward branch halt", pc_o, 32'd76);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule